// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses for one read or write burst of a synchronous DRAM. A start pulse loads a starting column together with the decoded burst fields: a 3-bit length code, an ordering bit that selects sequential or interleaved order, a bit that marks the access as a write, and a single-write mode bit. The block then presents one column address per beat on a valid/ready output stream and flags the final beat.

Each accepted beat (valid and ready high at the same clock edge) moves the stream to the next column. When ready is low, the current address and the last-beat flag stay unchanged until the beat is taken, so the data path can stall the sequence at any point. A burst ends in one of three ways. The final beat of a fixed-length burst is accepted. A terminate pulse arrives. A new start arrives and replaces the burst in progress. A full-page burst has no final beat and runs until it is terminated or restarted.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low and stay low until a start is applied.
- R2: A start pulse makes `out_valid` high at the next clock edge, with `out_col` equal to the start column sampled with the pulse.
- R3: While `out_valid` is high and `out_ready` is low, with no start and no terminate, `out_col`, `out_last` and `out_valid` keep their values at the next edge.
- R4: Length codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. `out_last` is high on the final beat only, and accepting that beat drops `out_valid` at the next edge.
- R5: Length codes 4, 5 and 6 give a burst of one beat.
- R6: In sequential order (ordering bit 0), beat n of a burst of length L has its low log2(L) bits equal to (start + n) mod L. The upper bits stay at those of the start column.
- R7: In interleaved order (ordering bit 1), beat n has its low log2(L) bits equal to the start column's low bits XOR n. The upper bits are unchanged.
- R8: Length code 7 is a full-page burst. Each beat adds one to the column modulo 512, so column 511 is followed by column 0. The ordering bit has no effect, `out_last` never rises, and the burst continues until it is terminated.
- R9: When single-write mode is set and the access is a write, the burst is one beat long whatever the length code. A read with single-write mode set uses the length code.
- R10: A terminate pulse without a start drops `out_valid` at the next edge, whether or not a beat is accepted in the same cycle.
- R11: A start during an active burst abandons that burst. The next edge presents the new start column, and the new burst follows its own length and order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a burst with the fields below |
| start_col | input | 9 | Starting column |
| len_code | input | 3 | Burst length code |
| order_il | input | 1 | 1 = interleaved order, 0 = sequential |
| is_write | input | 1 | The burst is a write |
| single_wr | input | 1 | Single-write mode |
| terminate | input | 1 | End the current burst |
| out_valid | output | 1 | A column address is presented |
| out_ready | input | 1 | The consumer takes the current beat |
| out_col | output | 9 | Column address of the current beat |
| out_last | output | 1 | The current beat is the final one |

## Verification
A beat counter that is off by one shows at `out_col` on the first accepted beat after the fault. It also moves `out_last` by one beat, which lengthens or shortens the burst, and the expected beat-by-beat sequence exposes that within one burst. A wrongly latched length, order or start column shows at the beat where the sequence first wraps or first departs from the XOR pattern. An active flag that fails to clear shows as a stray `out_valid` on the cycle after the final beat or after a terminate. Restart and back-pressure faults show in the cycle that follows the stimulus.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int MAX_LOG   = 3;
  localparam int LOG_W     = $clog2(MAX_LOG + 1);
  localparam int CODE_W    = 3;
  localparam logic [CODE_W-1:0] CODE_PAGE = 3'd7;

  typedef struct packed {
    logic [LOG_W-1:0] lg;
    logic             page;
  } burst_len_t;
endpackage

// File: rtl/bcs_len_dec.sv
module bcs_len_dec
  import bcs_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              is_write,
  input  logic              single_wr,
  output burst_len_t        len
);
  always_comb begin
    len = '0;
    if (code == CODE_PAGE) begin
      len.page = 1'b1;
    end else if (code <= CODE_W'(MAX_LOG)) begin
      len.lg = LOG_W'(code);
    end
    if (is_write && single_wr) begin
      len = '0;
    end
  end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
  import bcs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [COL_W-1:0] beat,
  input  burst_len_t       len,
  input  logic             il,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] seq_sum;

  assign mask    = (COL_W'(1) << len.lg) - COL_W'(1);
  assign seq_sum = base_col + beat;

  always_comb begin
    if (len.page) begin
      col = seq_sum;
    end else if (il) begin
      col = (base_col & ~mask) | ((base_col ^ beat) & mask);
    end else begin
      col = (base_col & ~mask) | (seq_sum & mask);
    end
  end
endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             terminate,
  input  logic             ready,
  input  burst_len_t       len,
  output logic             active,
  output logic [COL_W-1:0] beat,
  output logic             last
);
  logic [COL_W-1:0] final_beat;
  logic             fire;

  assign final_beat = (COL_W'(1) << len.lg) - COL_W'(1);
  assign last       = active && !len.page && (beat == final_beat);
  assign fire       = active && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
    end else if (start) begin
      active <= 1'b1;
      beat   <= '0;
    end else if (terminate) begin
      active <= 1'b0;
      beat   <= '0;
    end else if (fire) begin
      if (last) begin
        active <= 1'b0;
        beat   <= '0;
      end else begin
        beat <= beat + COL_W'(1);
      end
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic [CODE_W-1:0] len_code,
  input  logic              order_il,
  input  logic              is_write,
  input  logic              single_wr,
  input  logic              terminate,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [COL_W-1:0]  out_col,
  output logic              out_last
);
  burst_len_t       dec_len;
  burst_len_t       held_len;
  logic [COL_W-1:0] held_col;
  logic             held_il;
  logic             active;
  logic [COL_W-1:0] beat;

  bcs_len_dec u_dec (
    .code      (len_code),
    .is_write  (is_write),
    .single_wr (single_wr),
    .len       (dec_len)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_len <= '0;
      held_col <= '0;
      held_il  <= 1'b0;
    end else if (start) begin
      held_len <= dec_len;
      held_col <= start_col;
      held_il  <= order_il;
    end
  end

  bcs_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .terminate (terminate),
    .ready     (out_ready),
    .len       (held_len),
    .active    (active),
    .beat      (beat),
    .last      (out_last)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_col (held_col),
    .beat     (beat),
    .len      (held_len),
    .il       (held_il),
    .col      (out_col)
  );

  assign out_valid = active;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             terminate,
  input logic             out_valid,
  input logic             out_ready,
  input logic [COL_W-1:0] out_col,
  input logic             out_last
);
  assert_idle_no_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_last);

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (out_valid && out_col == $past(start_col)));

  assert_hold_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start && !terminate)
      |=> (out_valid && $stable(out_col) && $stable(out_last)));

  assert_last_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && !start && !terminate) |=> !out_valid);

  assert_term_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (terminate && !start) |=> !out_valid);
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .start_col (start_col),
  .terminate (terminate),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_col   (out_col),
  .out_last  (out_last)
);

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb;
  localparam int COL_W = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       len_code = '0;
  logic             order_il = 1'b0;
  logic             is_write = 1'b0;
  logic             single_wr = 1'b0;
  logic             terminate = 1'b0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [COL_W-1:0] out_col;
  logic             out_last;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .order_il(order_il), .is_write(is_write),
    .single_wr(single_wr), .terminate(terminate), .out_valid(out_valid),
    .out_ready(out_ready), .out_col(out_col), .out_last(out_last)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ref_col(int s, int len, bit il, int n);
    int m;
    if (len == 512) return (s + n) % 512;
    m = len - 1;
    if (il) return (s & ~m & 511) | ((s ^ n) & m);
    return (s & ~m & 511) | ((s + n) & m);
  endfunction

  task automatic issue(input int s, input int code, input bit il, input bit wr, input bit sw);
    start_col = COL_W'(s);
    len_code  = 3'(code);
    order_il  = il;
    is_write  = wr;
    single_wr = sw;
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
  endtask

  task automatic run_burst(input string tag, input int s, input int code, input bit il,
                           input bit wr, input bit sw, input int len);
    issue(s, code, il, wr, sw);
    for (int n = 0; n < len; n++) begin
      check(out_valid == 1'b1, {tag, " valid"}, int'(out_valid), 1);
      check(int'(out_col) == ref_col(s, len, il, n), {tag, " col"}, int'(out_col), ref_col(s, len, il, n));
      check(out_last == (n == len - 1), {tag, " last"}, int'(out_last), int'(n == len - 1));
      @(negedge clk);
    end
    check(out_valid == 1'b0, {tag, " end"}, int'(out_valid), 0);
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_last == 1'b0, "R1 idle after reset", int'(out_valid), 0);
  endtask

  task automatic t_fixed_seq();
    run_burst("R4 R2 len1", 37, 0, 0, 0, 0, 1);
    run_burst("R4 len2", 37, 1, 0, 0, 0, 2);
    run_burst("R4 R6 len4 wrap", 6, 2, 0, 0, 0, 4);
    run_burst("R6 len8 wrap", 13, 3, 0, 0, 0, 8);
  endtask

  task automatic t_undef();
    for (int c = 4; c < 7; c++) run_burst("R5 undefined code", 100 + c, c, 0, 0, 0, 1);
  endtask

  task automatic t_interleave();
    run_burst("R7 il len4", 6, 2, 1, 0, 0, 4);
    run_burst("R7 il len8", 205, 3, 1, 0, 0, 8);
    run_burst("R7 il len2", 3, 1, 1, 0, 0, 2);
  endtask

  task automatic t_fullpage();
    issue(509, 7, 1, 0, 0);
    for (int n = 0; n < 6; n++) begin
      check(out_valid && int'(out_col) == (509 + n) % 512, "R8 page col", int'(out_col), (509 + n) % 512);
      check(out_last == 1'b0, "R8 page no last", int'(out_last), 0);
      @(negedge clk);
    end
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;
    check(out_valid == 1'b0, "R10 terminate page", int'(out_valid), 0);
  endtask

  task automatic t_single_write();
    run_burst("R9 single write", 20, 3, 0, 1, 1, 1);
    run_burst("R9 read keeps length", 20, 2, 0, 0, 1, 4);
    run_burst("R9 write no mode", 20, 1, 0, 1, 0, 2);
  endtask

  task automatic t_backpressure();
    issue(40, 2, 0, 0, 0);
    out_ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_valid && out_col == 9'd40, "R3 stall hold", int'(out_col), 40);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check(out_col == 9'd41, "R3 resume", int'(out_col), 41);
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;
    check(out_valid == 1'b0, "R10 terminate fixed", int'(out_valid), 0);
  endtask

  task automatic t_restart();
    issue(16, 3, 0, 0, 0);
    @(negedge clk);
    check(out_col == 9'd17, "R11 first burst", int'(out_col), 17);
    issue(300, 1, 1, 0, 0);
    check(out_valid && out_col == 9'd300, "R11 restart col", int'(out_col), 300);
    check(out_last == 1'b0, "R11 restart last", int'(out_last), 0);
    @(negedge clk);
    check(out_col == 9'd301 && out_last, "R11 restart beat1", int'(out_col), 301);
    @(negedge clk);
    check(out_valid == 1'b0, "R11 restart end", int'(out_valid), 0);
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_fixed_seq();
    t_undef();
    t_interleave();
    t_fullpage();
    t_single_write();
    t_backpressure();
    t_restart();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule